// File: doc/BRIEF.md
# Single-Bus Register Datapath

This block is the register side of a simple processor datapath built around one shared 32-bit internal bus. In any cycle the bus carries exactly one value. That value comes from one of these sources: sixteen general registers, the HI and LO result registers, the upper or lower half of a 64-bit result register Z, the program counter, the memory data register, an external input word, or a sign-extended constant.

Each source has an "out" strobe. The strobes are gathered into a 32-bit vector, encoded into a 5-bit select, and that select steers a 32:1 multiplexer. Each destination register has an "in" strobe and captures the bus value on the rising clock edge. Y captures the bus so that it can hold one ALU operand while the other operand travels on the bus. MAR and IR also load from the bus. Z loads a 64-bit ALU result. The memory data register loads either from the bus or from memory read data, and its contents feed both the bus and the memory write path.

The ALU, memory, instruction decoding and the control sequencer sit outside this block. Their signals arrive as plain inputs.

Top module: `bus_datapath`

## Requirements
- R1: A synchronous clear sets every register (general registers, HI, LO, Z, PC, MDR, Y, MAR, IR) to zero at the next rising edge.
- R2: When no out strobe is asserted, the bus value is zero.
- R3: The bus shows the source at the asserted strobe's index. General register n is index n (0 to 15), HI is 16, LO is 17, Z upper half is 18, Z lower half is 19, PC is 20, MDR is 21, the input word is 22 and the constant is 23.
- R4: When several out strobes are asserted together, the source with the highest index drives the bus.
- R5: A general register, HI, LO or PC with its in strobe high takes the bus value at the next rising edge. Every register whose in strobe is low keeps its value.
- R6: With its load strobe high, Z takes the 64-bit ALU result at the next rising edge. Bits 63:32 read on the bus as source 18 and bits 31:0 as source 19.
- R7: When its load strobe is high, MDR takes memory read data if the read select is high, and the bus value if it is low. The MDR contents appear on the memory write-data output at all times.
- R8: The constant source drives its IMM_W-bit input on the bus with bit IMM_W-1 copied into all upper bits (default IMM_W = 19).
- R9: Y, MAR and IR take the bus value at the next rising edge when their own in strobe is high, and hold otherwise. Their contents are visible on dedicated outputs.
- R10: Clear takes priority over every load strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| clr_i | input | 1 | Synchronous clear of all registers |
| gpr_out_i | input | 16 | Out strobes of general registers 0 to 15 |
| gpr_in_i | input | 16 | In strobes of general registers 0 to 15 |
| hi_out_i | input | 1 | HI drives the bus |
| hi_in_i | input | 1 | HI loads from the bus |
| lo_out_i | input | 1 | LO drives the bus |
| lo_in_i | input | 1 | LO loads from the bus |
| zhi_out_i | input | 1 | Z bits 63:32 drive the bus |
| zlo_out_i | input | 1 | Z bits 31:0 drive the bus |
| z_in_i | input | 1 | Z loads the ALU result |
| alu_res_i | input | 64 | ALU result |
| pc_out_i | input | 1 | PC drives the bus |
| pc_in_i | input | 1 | PC loads from the bus |
| mdr_out_i | input | 1 | MDR drives the bus |
| mdr_in_i | input | 1 | MDR load strobe |
| mem_rd_i | input | 1 | MDR source select: 1 memory data, 0 bus |
| mem_rdata_i | input | 32 | Memory read data |
| inp_out_i | input | 1 | Input word drives the bus |
| inp_data_i | input | 32 | External input word |
| imm_out_i | input | 1 | Sign-extended constant drives the bus |
| imm_i | input | 19 | Constant before sign extension |
| y_in_i | input | 1 | Y loads from the bus |
| mar_in_i | input | 1 | MAR loads from the bus |
| ir_in_i | input | 1 | IR loads from the bus |
| bus_o | output | 32 | Current bus value |
| y_o | output | 32 | Y contents (ALU A operand) |
| z_o | output | 64 | Z contents |
| mar_o | output | 32 | MAR contents |
| ir_o | output | 32 | IR contents |
| mdr_o | output | 32 | MDR contents (memory write data) |

## Verification
The bus is combinational from strobes and register contents, so its value is due in the same cycle the strobes are applied. The bench drives strobes just after a falling edge and compares the bus one time unit later, before the next rising edge. Every register load appears one rising edge later. The bench updates its model at that edge, using the bus value it predicted for the cycle, and compares Y, MAR, IR, MDR and Z one time unit after the edge. Registers that have no dedicated output are checked in a later cycle by reading them back onto the bus.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

   // Fixed bus source index map; the select encoding depends on it.
   localparam int unsigned NUM_GPR   = 16;
   localparam int unsigned SRC_HI    = 16;
   localparam int unsigned SRC_LO    = 17;
   localparam int unsigned SRC_ZH    = 18;
   localparam int unsigned SRC_ZL    = 19;
   localparam int unsigned SRC_PC    = 20;
   localparam int unsigned SRC_MDR   = 21;
   localparam int unsigned SRC_INP   = 22;
   localparam int unsigned SRC_IMM   = 23;
   localparam int unsigned NUM_USED  = 24;
   localparam int unsigned NUM_SLOTS = 32;
   localparam int unsigned SEL_W     = $clog2(NUM_SLOTS);

endpackage

// File: rtl/bdp_reg.sv
module bdp_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         clr_i,
   input  logic         ld_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("bdp_reg: W must be at least 1");
   end

   always_ff @(posedge clk_i) begin
      if (clr_i)     q_o <= '0;
      else if (ld_i) q_o <= d_i;
   end

   AST_CLR_ZERO: assert property (@(posedge clk_i) clr_i |=> (q_o == '0))
      else $error("clear did not zero register"); // R1

   AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (clr_i)
      ld_i |=> (q_o == $past(d_i)))
      else $error("load did not capture data"); // R5

   AST_HOLD_VALUE: assert property (@(posedge clk_i) disable iff (clr_i)
      !ld_i |=> $stable(q_o))
      else $error("register changed without load"); // R9

endmodule

// File: rtl/bdp_prio_enc.sv
module bdp_prio_enc #(
   parameter int unsigned N     = 32,
   parameter int unsigned SEL_W = $clog2(N)
) (
   input  logic [N-1:0]     strobes_i,
   output logic [SEL_W-1:0] sel_o,
   output logic             any_o
);

   if (N < 2 || (1 << SEL_W) < N) begin : g_bad_n
      $error("bdp_prio_enc: select too narrow for N");
   end

   always_comb begin
      sel_o = '0;
      any_o = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (strobes_i[i]) begin
            sel_o = SEL_W'(i);
            any_o = 1'b1;
         end
      end
   end

   always_comb begin
      if (!$isunknown(strobes_i) && any_o) begin
         AST_SEL_IS_HIGHEST: assert ((strobes_i >> sel_o) == N'(1))
            else $error("encoder did not pick highest strobe"); // R4
      end
   end

endmodule

// File: rtl/bdp_bus_mux.sv
module bdp_bus_mux #(
   parameter int unsigned W     = 32,
   parameter int unsigned N     = 32,
   parameter int unsigned SEL_W = $clog2(N)
) (
   input  logic [N-1:0][W-1:0] src_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic                any_i,
   output logic [W-1:0]        bus_o
);

   if ((1 << SEL_W) != N) begin : g_bad_n
      $error("bdp_bus_mux: N must equal 2**SEL_W");
   end

   always_comb begin
      bus_o = '0;
      if (any_i) bus_o = src_i[sel_i];
   end

endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
   import bdp_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 19
) (
   input  logic                  clk_i,
   input  logic                  clr_i,
   input  logic [NUM_GPR-1:0]    gpr_out_i,
   input  logic [NUM_GPR-1:0]    gpr_in_i,
   input  logic                  hi_out_i,
   input  logic                  hi_in_i,
   input  logic                  lo_out_i,
   input  logic                  lo_in_i,
   input  logic                  zhi_out_i,
   input  logic                  zlo_out_i,
   input  logic                  z_in_i,
   input  logic [2*DATA_W-1:0]   alu_res_i,
   input  logic                  pc_out_i,
   input  logic                  pc_in_i,
   input  logic                  mdr_out_i,
   input  logic                  mdr_in_i,
   input  logic                  mem_rd_i,
   input  logic [DATA_W-1:0]     mem_rdata_i,
   input  logic                  inp_out_i,
   input  logic [DATA_W-1:0]     inp_data_i,
   input  logic                  imm_out_i,
   input  logic [IMM_W-1:0]      imm_i,
   input  logic                  y_in_i,
   input  logic                  mar_in_i,
   input  logic                  ir_in_i,
   output logic [DATA_W-1:0]     bus_o,
   output logic [DATA_W-1:0]     y_o,
   output logic [2*DATA_W-1:0]   z_o,
   output logic [DATA_W-1:0]     mar_o,
   output logic [DATA_W-1:0]     ir_o,
   output logic [DATA_W-1:0]     mdr_o
);

   localparam int unsigned Z_W   = 2 * DATA_W;
   localparam int unsigned EXT_W = DATA_W - IMM_W;

   if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
      $error("bus_datapath: IMM_W must lie in 1..DATA_W");
   end

   logic [NUM_GPR-1:0][DATA_W-1:0]   gpr_q;
   logic [DATA_W-1:0]                hi_q, lo_q, pc_q;
   logic [NUM_SLOTS-1:0][DATA_W-1:0] src;
   logic [NUM_SLOTS-1:0]             strobes;
   logic [SEL_W-1:0]                 sel;
   logic                             any_src;
   logic [DATA_W-1:0]                bus;
   logic [DATA_W-1:0]                imm_ext;
   logic [DATA_W-1:0]                mdr_d;

   // General registers
   for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
      bdp_reg #(.W(DATA_W)) u_gpr (
         .clk_i(clk_i), .clr_i(clr_i), .ld_i(gpr_in_i[g]),
         .d_i(bus), .q_o(gpr_q[g]));
   end

   bdp_reg #(.W(DATA_W)) u_hi (.clk_i(clk_i), .clr_i(clr_i), .ld_i(hi_in_i),
      .d_i(bus), .q_o(hi_q));
   bdp_reg #(.W(DATA_W)) u_lo (.clk_i(clk_i), .clr_i(clr_i), .ld_i(lo_in_i),
      .d_i(bus), .q_o(lo_q));
   bdp_reg #(.W(DATA_W)) u_pc (.clk_i(clk_i), .clr_i(clr_i), .ld_i(pc_in_i),
      .d_i(bus), .q_o(pc_q));
   bdp_reg #(.W(DATA_W)) u_y (.clk_i(clk_i), .clr_i(clr_i), .ld_i(y_in_i),
      .d_i(bus), .q_o(y_o));
   bdp_reg #(.W(DATA_W)) u_mar (.clk_i(clk_i), .clr_i(clr_i), .ld_i(mar_in_i),
      .d_i(bus), .q_o(mar_o));
   bdp_reg #(.W(DATA_W)) u_ir (.clk_i(clk_i), .clr_i(clr_i), .ld_i(ir_in_i),
      .d_i(bus), .q_o(ir_o));
   bdp_reg #(.W(Z_W)) u_z (.clk_i(clk_i), .clr_i(clr_i), .ld_i(z_in_i),
      .d_i(alu_res_i), .q_o(z_o));

   // MDR with its two-source input select
   always_comb mdr_d = mem_rd_i ? mem_rdata_i : bus;

   bdp_reg #(.W(DATA_W)) u_mdr (.clk_i(clk_i), .clr_i(clr_i), .ld_i(mdr_in_i),
      .d_i(mdr_d), .q_o(mdr_o));

   // Constant sign extension
   if (EXT_W == 0) begin : g_imm_full
      assign imm_ext = imm_i;
   end else begin : g_imm_ext
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   end

   // Source table in index order
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_src
      if (s < NUM_GPR) begin : g_is_gpr
         assign src[s] = gpr_q[s];
      end else if (s == SRC_HI)  begin : g_is_hi
         assign src[s] = hi_q;
      end else if (s == SRC_LO)  begin : g_is_lo
         assign src[s] = lo_q;
      end else if (s == SRC_ZH)  begin : g_is_zh
         assign src[s] = z_o[Z_W-1:DATA_W];
      end else if (s == SRC_ZL)  begin : g_is_zl
         assign src[s] = z_o[DATA_W-1:0];
      end else if (s == SRC_PC)  begin : g_is_pc
         assign src[s] = pc_q;
      end else if (s == SRC_MDR) begin : g_is_mdr
         assign src[s] = mdr_o;
      end else if (s == SRC_INP) begin : g_is_inp
         assign src[s] = inp_data_i;
      end else if (s == SRC_IMM) begin : g_is_imm
         assign src[s] = imm_ext;
      end else begin : g_unused
         assign src[s] = '0;
      end
   end

   assign strobes = {{(NUM_SLOTS - NUM_USED){1'b0}},
                     imm_out_i, inp_out_i, mdr_out_i, pc_out_i,
                     zlo_out_i, zhi_out_i, lo_out_i, hi_out_i, gpr_out_i};

   bdp_prio_enc #(.N(NUM_SLOTS), .SEL_W(SEL_W)) u_enc (
      .strobes_i(strobes), .sel_o(sel), .any_o(any_src));

   bdp_bus_mux #(.W(DATA_W), .N(NUM_SLOTS), .SEL_W(SEL_W)) u_mux (
      .src_i(src), .sel_i(sel), .any_i(any_src), .bus_o(bus));

   assign bus_o = bus;

   always_comb begin
      if (!$isunknown(strobes) && strobes == '0) begin
         AST_IDLE_BUS_ZERO: assert (bus == '0)
            else $error("idle bus not zero"); // R2
      end
   end

   AST_MDR_FROM_MEM: assert property (@(posedge clk_i) disable iff (clr_i)
      (mdr_in_i && mem_rd_i) |=> (mdr_o == $past(mem_rdata_i)))
      else $error("MDR did not take memory data"); // R7

   AST_MDR_FROM_BUS: assert property (@(posedge clk_i) disable iff (clr_i)
      (mdr_in_i && !mem_rd_i) |=> (mdr_o == $past(bus)))
      else $error("MDR did not take bus data"); // R7

   AST_ZHI_ON_BUS: assert property (@(posedge clk_i) disable iff (clr_i)
      (zhi_out_i && strobes[NUM_SLOTS-1:SRC_ZH+1] == '0) |-> (bus == z_o[Z_W-1:DATA_W]))
      else $error("Z upper half not on bus"); // R6

endmodule

// File: tb/bus_datapath_bench.sv
module bus_datapath_bench;

   localparam int CLK_P = 10;
   localparam int DW    = 32;
   localparam int IW    = 19;

   logic          clk = 1'b0;
   logic          clr = 1'b1;
   logic [31:0]   outs = '0;      // bit n = out strobe of source index n
   logic [15:0]   gin = '0;
   logic          hi_ld = 0, lo_ld = 0, pc_ld = 0, mdr_ld = 0, z_ld = 0;
   logic          y_ld = 0, mar_ld = 0, ir_ld = 0, mem_rd = 0;
   logic [63:0]   alu = '0;
   logic [31:0]   mrd = '0, inp = '0;
   logic [IW-1:0] imm = '0;
   logic [31:0]   bus_w, y_w, mar_w, ir_w, mdr_w;
   logic [63:0]   z_w;

   // model
   logic [31:0] m_gpr [16];
   logic [31:0] m_hi, m_lo, m_pc, m_mdr, m_y, m_mar, m_ir;
   logic [63:0] m_z;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   bus_datapath #(.DATA_W(DW), .IMM_W(IW)) u_bus_datapath (
      .clk_i(clk), .clr_i(clr),
      .gpr_out_i(outs[15:0]), .gpr_in_i(gin),
      .hi_out_i(outs[16]), .hi_in_i(hi_ld),
      .lo_out_i(outs[17]), .lo_in_i(lo_ld),
      .zhi_out_i(outs[18]), .zlo_out_i(outs[19]), .z_in_i(z_ld), .alu_res_i(alu),
      .pc_out_i(outs[20]), .pc_in_i(pc_ld),
      .mdr_out_i(outs[21]), .mdr_in_i(mdr_ld), .mem_rd_i(mem_rd), .mem_rdata_i(mrd),
      .inp_out_i(outs[22]), .inp_data_i(inp),
      .imm_out_i(outs[23]), .imm_i(imm),
      .y_in_i(y_ld), .mar_in_i(mar_ld), .ir_in_i(ir_ld),
      .bus_o(bus_w), .y_o(y_w), .z_o(z_w), .mar_o(mar_w), .ir_o(ir_w), .mdr_o(mdr_w));

   task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] src_val(int idx);
      if (idx < 16) return m_gpr[idx];
      case (idx)
         16: return m_hi;
         17: return m_lo;
         18: return m_z[63:32];
         19: return m_z[31:0];
         20: return m_pc;
         21: return m_mdr;
         22: return inp;
         23: return {{(32-IW){imm[IW-1]}}, imm};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_bus();
      logic [31:0] v = '0;
      for (int i = 0; i < 24; i++) if (outs[i]) v = src_val(i);
      return v;
   endfunction

   function automatic string bus_tag();
      int c = $countones(outs[23:0]);
      if (c == 0) return "R2";
      if (c > 1) return "R4";
      if (outs[23]) return "R8";
      if (outs[18] || outs[19]) return "R6";
      return "R3";
   endfunction

   task automatic idle();
      outs = '0; gin = '0; hi_ld = 0; lo_ld = 0; pc_ld = 0; mdr_ld = 0;
      z_ld = 0; y_ld = 0; mar_ld = 0; ir_ld = 0; mem_rd = 0; clr = 0;
   endtask

   // inputs already set after a falling edge
   task automatic run_cycle(string tag);
      logic [31:0] eb;
      string t;
      #1;
      eb = exp_bus();
      t = (tag == "") ? bus_tag() : tag;
      chk(t, {32'h0, bus_w}, {32'h0, eb});
      @(posedge clk);
      if (clr) begin
         for (int i = 0; i < 16; i++) m_gpr[i] = '0;
         m_hi = '0; m_lo = '0; m_pc = '0; m_mdr = '0; m_y = '0;
         m_mar = '0; m_ir = '0; m_z = '0;
      end else begin
         for (int i = 0; i < 16; i++) if (gin[i]) m_gpr[i] = eb;
         if (hi_ld)  m_hi  = eb;
         if (lo_ld)  m_lo  = eb;
         if (pc_ld)  m_pc  = eb;
         if (y_ld)   m_y   = eb;
         if (mar_ld) m_mar = eb;
         if (ir_ld)  m_ir  = eb;
         if (mdr_ld) m_mdr = mem_rd ? mrd : eb;
         if (z_ld)   m_z   = alu;
      end
      #1;
      t = clr ? "R10" : "R9";
      chk(t, {32'h0, y_w},   {32'h0, m_y});
      chk(t, {32'h0, mar_w}, {32'h0, m_mar});
      chk(t, {32'h0, ir_w},  {32'h0, m_ir});
      chk(clr ? "R10" : "R7", {32'h0, mdr_w}, {32'h0, m_mdr});
      chk(clr ? "R10" : "R6", z_w, m_z);
      @(negedge clk);
   endtask

   task automatic read_src(int idx, string tag);
      idle(); outs[idx] = 1'b1; run_cycle(tag);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) m_gpr[i] = 'x;
      @(negedge clk);
      // R1 / R10: clear with every load strobe raised
      idle(); clr = 1; gin = '1; hi_ld = 1; lo_ld = 1; pc_ld = 1; mdr_ld = 1;
      z_ld = 1; y_ld = 1; mar_ld = 1; ir_ld = 1; alu = 64'hDEAD_BEEF_0123_4567;
      inp = 32'hFFFF_FFFF; outs[22] = 1; run_cycle("R10");
      for (int s = 0; s < 22; s++) read_src(s, "R1");
      // R2: idle bus
      idle(); inp = 32'h1234_5678; run_cycle("R2");
      // R5: load each general register from the input word, then read back
      for (int r = 0; r < 16; r++) begin
         idle(); inp = 32'hA500_0000 + 32'(r * 32'h0101_0101); outs[22] = 1; gin[r] = 1;
         run_cycle("R5");
      end
      for (int r = 0; r < 16; r++) read_src(r, "R5");
      // R5: HI, LO, PC loaded from different GPRs
      idle(); outs[3] = 1; hi_ld = 1; run_cycle("R5");
      idle(); outs[7] = 1; lo_ld = 1; pc_ld = 1; run_cycle("R5");
      read_src(16, "R3"); read_src(17, "R3"); read_src(20, "R3");
      // R4: simultaneous strobes
      idle(); outs[2] = 1; outs[9] = 1; run_cycle("R4");
      idle(); outs[0] = 1; outs[17] = 1; outs[22] = 1; inp = 32'h0BAD_F00D; run_cycle("R4");
      idle(); outs = 32'h00FF_FFFF; imm = 19'h4_0001; run_cycle("R4");
      // R8: negative and positive constants
      idle(); outs[23] = 1; imm = 19'h7_FFFF; run_cycle("R8");
      idle(); outs[23] = 1; imm = 19'h3_ABCD; y_ld = 1; run_cycle("R8");
      // R6: Z capture and halves
      idle(); z_ld = 1; alu = 64'h8765_4321_0FED_CBA9; run_cycle("R6");
      read_src(18, "R6"); read_src(19, "R6");
      // R7: MDR from memory, then from bus
      idle(); mdr_ld = 1; mem_rd = 1; mrd = 32'hC0DE_CAFE; outs[5] = 1; run_cycle("R7");
      read_src(21, "R7");
      idle(); mdr_ld = 1; mem_rd = 0; mrd = 32'h1111_1111; outs[11] = 1; run_cycle("R7");
      // R9: MAR and IR load, then hold
      idle(); outs[4] = 1; mar_ld = 1; ir_ld = 1; run_cycle("R9");
      idle(); outs[6] = 1; run_cycle("R9");
      // constrained random mix
      void'($urandom(32'd2023));
      for (int k = 0; k < 600; k++) begin
         int pick;
         idle();
         pick = int'($urandom_range(0, 9));
         if (pick != 0) outs[$urandom_range(0, 23)] = 1'b1;
         if (pick == 9) outs[$urandom_range(0, 23)] = 1'b1;
         for (int r = 0; r < 16; r++) gin[r] = ($urandom_range(0, 7) == 0);
         hi_ld = ($urandom_range(0, 5) == 0); lo_ld = ($urandom_range(0, 5) == 0);
         pc_ld = ($urandom_range(0, 5) == 0); mdr_ld = ($urandom_range(0, 3) == 0);
         z_ld = ($urandom_range(0, 3) == 0); y_ld = ($urandom_range(0, 3) == 0);
         mar_ld = ($urandom_range(0, 3) == 0); ir_ld = ($urandom_range(0, 3) == 0);
         mem_rd = $urandom_range(0, 1) == 1;
         clr = ($urandom_range(0, 63) == 0);
         alu = {$urandom, $urandom}; mrd = $urandom; inp = $urandom;
         imm = IW'($urandom);
         run_cycle("");
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule